// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into an absolute address. It walks up to three levels of region tables, then a segment table, then a page table. Each table entry is 8 bytes and is read through a simple request/response port, with one fetch in flight at a time. A request carries the virtual address, a 64-bit address-space descriptor, two large-frame enables and a fetch/store flag. The result is either a translated address or a single exception code, reported with a one-cycle done pulse.

The descriptor picks the level at which the walk starts. Every entry is checked for an invalid bit, a table-type tag and, in region entries, an index window for the next level. When a large-frame format is enabled, a region-third or segment entry can end the walk early. A protection bit is OR-gathered along the way, and a store to a protected page is refused. The memory side returns an out-of-range flag with each response. That flag is the block's only range check.

Top module: `dat_walker`

## Requirements
- R1: When descriptor bit 5 (real space) is set, no fetch is made, and done returns the input address unchanged with no exception.
- R2: The virtual address splits, top down, into three 11-bit region indices (first [63:53], second [52:42], third [41:31]), an 11-bit segment index [30:20], an 8-bit page index [19:12] and a 12-bit byte offset. A region or segment entry is read at origin×4096 + index×8. A page entry is read at page-table origin (entry bits 63:11)×2048 + page index×8. The result is the page frame (bits 63:12) joined with the byte offset.
- R3: Descriptor bits 3:2 select the first table: 3 region-first, 2 region-second, 1 region-third, 0 segment. A nonzero index above the starting level raises the ASCE-type exception without any fetch.
- R4: If the top two bits of the starting index exceed descriptor bits 1:0, the starting level's translation exception is raised without any fetch.
- R5: A region or segment entry with bit 5 set raises that level's translation exception.
- R6: An entry whose bits 3:2 differ from its level number raises the translation-specification exception.
- R7: A region entry's bits 7:6 (low bound) and 1:0 (high bound) limit the top two bits of the next level's index. A value outside the window raises the next level's translation exception.
- R8: A region-third entry with bit 10 set and the second enable on ends the walk with address {entry[63:31], va[30:0]}. A segment entry with bit 10 set and the first enable on ends it with {entry[63:20], va[19:0]}. With the enable off, bit 10 is ignored.
- R9: Bit 4 of a segment entry, or of a region-third entry while the second enable is on, together with descriptor bit 8 (private), raises the translation-specification exception.
- R10: A page entry with bit 10 set raises the page-translation exception. Bit 11 set, or bit 8 set while the first enable is off, raises translation-specification.
- R11: Bit 9 of every entry is OR-accumulated as protection, and region entries contribute only when the first enable is on. A store whose walk ends with protection set raises the protection exception. A fetch is not affected.
- R12: A response returned with the out-of-range flag raises the addressing exception.
- R13: Each fetch request is a one-cycle pulse at an 8-byte-aligned address. A new request is never issued before the previous one has been answered. A start while busy is ignored.
- R14: Done pulses for one cycle with result_exc coded 0 none, 1 ASCE-type, 2 region-first, 3 region-second, 4 region-third, 5 segment, 6 page, 7 translation-specification, 8 protection, 9 addressing. The address is zero whenever an exception is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (taken only when idle) |
| vaddr | input | 64 | Virtual address to translate |
| space_desc | input | 64 | Address-space descriptor (origin, private, real, type, length) |
| lf1_en | input | 1 | First large-frame enable |
| lf2_en | input | 1 | Second large-frame enable |
| is_store | input | 1 | Access is a store (1) or a fetch (0) |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | One-cycle entry fetch request |
| mem_req_addr | output | 64 | Address of the entry to fetch |
| mem_rsp_valid | input | 1 | Entry data is returned |
| mem_rsp_data | input | 64 | Fetched entry |
| mem_rsp_oor | input | 1 | Fetched address was out of range |
| done | output | 1 | One-cycle result pulse |
| result_addr | output | 64 | Translated address |
| result_exc | output | 4 | Exception code |

## Verification
The field widths are fixed by the entry formats, so the bench builds the block with its package defaults. It sets its own memory response latency to several cycles, so every walk spans many idle cycles between fetches. That makes it possible to inject a start while a five-fetch walk from the region-first level is still running. Table contents are placed so that each start level, each early-ending large frame and each window bound is reached. The bench also counts fetches to confirm how deep each walk went.

// File: rtl/dat_walk_pkg.sv
package dat_walk_pkg;

    localparam int VA_W          = 64;
    localparam int RX_W          = 11;
    localparam int PX_W          = 8;
    localparam int BX_W          = 12;
    localparam int NLVL          = 4;
    localparam int LVL_W         = $clog2(NLVL);
    localparam int ORG_LSB       = 12;
    localparam int PTO_LSB       = 11;
    localparam int R3_FRAME_LSB  = 31;
    localparam int SEG_FRAME_LSB = 20;
    localparam int IDX_BASE      = BX_W + PX_W;
    localparam int EXC_W         = 4;

    typedef enum logic [EXC_W-1:0] {
        EXC_NONE      = 4'd0,
        EXC_ASCE_TYPE = 4'd1,
        EXC_REG1      = 4'd2,
        EXC_REG2      = 4'd3,
        EXC_REG3      = 4'd4,
        EXC_SEG       = 4'd5,
        EXC_PAGE      = 4'd6,
        EXC_SPEC      = 4'd7,
        EXC_PROT      = 4'd8,
        EXC_ADDR      = 4'd9
    } exc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;

    function automatic exc_e level_exc(input logic [LVL_W-1:0] lvl);
        case (lvl)
            2'd3:    return EXC_REG1;
            2'd2:    return EXC_REG2;
            2'd1:    return EXC_REG3;
            default: return EXC_SEG;
        endcase
    endfunction

endpackage

// File: rtl/dat_va_index.sv
module dat_va_index
    import dat_walk_pkg::*;
(
    input  logic [VA_W-1:0]            va,
    output logic [NLVL-1:0][RX_W-1:0]  idx,
    output logic [NLVL-1:0]            above_nz,
    output logic [PX_W-1:0]            px
);
    assign px = va[BX_W +: PX_W];

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        assign idx[g] = va[IDX_BASE + g*RX_W +: RX_W];
        if (g == NLVL-1) begin : g_top
            assign above_nz[g] = 1'b0;
        end else begin : g_mid
            assign above_nz[g] = |va[VA_W-1 : IDX_BASE + (g+1)*RX_W];
        end
    end
endmodule

// File: rtl/dat_entry_eval.sv
module dat_entry_eval
    import dat_walk_pkg::*;
(
    input  logic [VA_W-1:0]           entry,
    input  logic                      oor,
    input  logic [LVL_W-1:0]          lvl,
    input  logic                      at_page,
    input  logic [VA_W-1:0]           va,
    input  logic [NLVL-1:0][RX_W-1:0] idx,
    input  logic [PX_W-1:0]           px,
    input  logic                      priv,
    input  logic                      e1,
    input  logic                      e2,
    output exc_e                      exc,
    output logic                      finish,
    output logic [VA_W-1:0]           res_addr,
    output logic [VA_W-1:0]           next_ptr,
    output logic                      next_page,
    output logic [LVL_W-1:0]          next_lvl,
    output logic                      prot_bit
);
    logic [LVL_W-1:0] nl;
    logic [1:0]       nidx_top;

    always_comb begin
        nl        = lvl - 2'd1;
        nidx_top  = idx[nl][RX_W-1 -: 2];
        exc       = EXC_NONE;
        finish    = 1'b0;
        res_addr  = '0;
        next_ptr  = '0;
        next_page = 1'b0;
        next_lvl  = nl;
        prot_bit  = 1'b0;

        if (oor) begin
            exc = EXC_ADDR;
        end else if (at_page) begin
            if (entry[10])                exc = EXC_PAGE;
            else if (entry[11])           exc = EXC_SPEC;
            else if (entry[8] && !e1)     exc = EXC_SPEC;
            else begin
                prot_bit = entry[9];
                finish   = 1'b1;
                res_addr = {entry[VA_W-1:ORG_LSB], va[ORG_LSB-1:0]};
            end
        end else if (entry[5]) begin
            exc = level_exc(lvl);
        end else if (entry[3:2] != lvl) begin
            exc = EXC_SPEC;
        end else if (lvl == 2'd0) begin
            if (entry[4] && priv) begin
                exc = EXC_SPEC;
            end else if (entry[10] && e1) begin
                prot_bit = entry[9];
                finish   = 1'b1;
                res_addr = {entry[VA_W-1:SEG_FRAME_LSB], va[SEG_FRAME_LSB-1:0]};
            end else begin
                prot_bit  = entry[9];
                next_page = 1'b1;
                next_ptr  = {entry[VA_W-1:PTO_LSB], {PTO_LSB{1'b0}}}
                          + 64'({px, 3'b000});
            end
        end else begin
            if (lvl == 2'd1 && entry[4] && priv && e2) begin
                exc = EXC_SPEC;
            end else if (lvl == 2'd1 && entry[10] && e2) begin
                prot_bit = entry[9];
                finish   = 1'b1;
                res_addr = {entry[VA_W-1:R3_FRAME_LSB], va[R3_FRAME_LSB-1:0]};
            end else if (nidx_top < entry[7:6] || nidx_top > entry[1:0]) begin
                exc = level_exc(nl);
            end else begin
                prot_bit = entry[9] & e1;
                next_ptr = {entry[VA_W-1:ORG_LSB], {ORG_LSB{1'b0}}}
                         + 64'({idx[nl], 3'b000});
            end
        end
    end
endmodule

// File: rtl/dat_walker.sv
module dat_walker
    import dat_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [VA_W-1:0]   space_desc,
    input  logic              lf1_en,
    input  logic              lf2_en,
    input  logic              is_store,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [VA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [VA_W-1:0]   mem_rsp_data,
    input  logic              mem_rsp_oor,
    output logic              done,
    output logic [VA_W-1:0]   result_addr,
    output logic [EXC_W-1:0]  result_exc
);
    typedef struct packed {
        st_e              st;
        logic [LVL_W-1:0] lvl;
        logic             page;
        logic             prot;
        logic [VA_W-1:0]  ptr;
        logic             req;
        logic             done;
        logic [VA_W-1:0]  res;
        exc_e             exc;
        logic [VA_W-1:0]  va;
        logic             priv;
        logic             e1;
        logic             e2;
        logic             store;
    } walk_s;

    walk_s s_d, s_q;

    logic [VA_W-1:0]           cur_va;
    logic [NLVL-1:0][RX_W-1:0] idx;
    logic [NLVL-1:0]           above_nz;
    logic [PX_W-1:0]           px;
    logic [LVL_W-1:0]          dt;
    logic                      unused_desc_bits;

    exc_e             ev_exc;
    logic             ev_finish;
    logic [VA_W-1:0]  ev_res;
    logic [VA_W-1:0]  ev_ptr;
    logic             ev_page;
    logic [LVL_W-1:0] ev_lvl;
    logic             ev_prot;

    assign cur_va           = (s_q.st == ST_IDLE) ? vaddr : s_q.va;
    assign dt               = space_desc[3:2];
    assign unused_desc_bits = ^{space_desc[11:9], space_desc[7:6], space_desc[4]};

    dat_va_index u_idx (
        .va       (cur_va),
        .idx      (idx),
        .above_nz (above_nz),
        .px       (px)
    );

    dat_entry_eval u_eval (
        .entry     (mem_rsp_data),
        .oor       (mem_rsp_oor),
        .lvl       (s_q.lvl),
        .at_page   (s_q.page),
        .va        (s_q.va),
        .idx       (idx),
        .px        (px),
        .priv      (s_q.priv),
        .e1        (s_q.e1),
        .e2        (s_q.e2),
        .exc       (ev_exc),
        .finish    (ev_finish),
        .res_addr  (ev_res),
        .next_ptr  (ev_ptr),
        .next_page (ev_page),
        .next_lvl  (ev_lvl),
        .prot_bit  (ev_prot)
    );

    always_comb begin
        s_d      = s_q;
        s_d.req  = 1'b0;
        s_d.done = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.va    = vaddr;
                    s_d.priv  = space_desc[8];
                    s_d.e1    = lf1_en;
                    s_d.e2    = lf2_en;
                    s_d.store = is_store;
                    s_d.prot  = 1'b0;
                    s_d.page  = 1'b0;
                    s_d.res   = '0;
                    if (space_desc[5]) begin
                        s_d.done = 1'b1;
                        s_d.res  = vaddr;
                        s_d.exc  = EXC_NONE;
                    end else if (above_nz[dt]) begin
                        s_d.done = 1'b1;
                        s_d.exc  = EXC_ASCE_TYPE;
                    end else if (idx[dt][RX_W-1 -: 2] > space_desc[1:0]) begin
                        s_d.done = 1'b1;
                        s_d.exc  = level_exc(dt);
                    end else begin
                        s_d.st  = ST_WAIT;
                        s_d.lvl = dt;
                        s_d.req = 1'b1;
                        s_d.ptr = {space_desc[VA_W-1:ORG_LSB], {ORG_LSB{1'b0}}}
                                + 64'({idx[dt], 3'b000});
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ev_exc != EXC_NONE) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.exc  = ev_exc;
                        s_d.res  = '0;
                    end else if (ev_finish) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        if (s_q.store && (s_q.prot || ev_prot)) begin
                            s_d.exc = EXC_PROT;
                            s_d.res = '0;
                        end else begin
                            s_d.exc = EXC_NONE;
                            s_d.res = ev_res;
                        end
                    end else begin
                        s_d.prot = s_q.prot | ev_prot;
                        s_d.ptr  = ev_ptr;
                        s_d.page = ev_page;
                        s_d.lvl  = ev_lvl;
                        s_d.req  = 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy          = (s_q.st != ST_IDLE);
    assign mem_req_valid = s_q.req;
    assign mem_req_addr  = s_q.ptr;
    assign done          = s_q.done;
    assign result_addr   = s_q.res;
    assign result_exc    = s_q.exc;
endmodule

// File: rtl/dat_walker_chk.sv
module dat_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_req_valid,
    input logic [63:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input logic        done
);
    logic pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             pending_q <= 1'b0;
        else if (mem_req_valid) pending_q <= 1'b1;
        else if (mem_rsp_valid) pending_q <= 1'b0;
    end

    a_r13_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !pending_q);

    a_r13_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    a_r13_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    a_r13_req_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r14_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind dat_walker dat_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done)
);

// File: tb/tb_dat_walker.sv
module tb_dat_walker;
    localparam time CLK_PERIOD = 10ns;
    localparam int  RSP_LAT    = 3;
    localparam logic [63:0] OOR_BASE = 64'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] vaddr = '0;
    logic [63:0] space_desc = '0;
    logic        lf1_en = 1'b0, lf2_en = 1'b0, is_store = 1'b0;
    logic        busy, mem_req_valid, done;
    logic [63:0] mem_req_addr, result_addr;
    logic        mem_rsp_valid = 1'b0, mem_rsp_oor = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic [3:0]  result_exc;

    always #(CLK_PERIOD/2) clk = ~clk;

    dat_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
        .space_desc(space_desc), .lf1_en(lf1_en), .lf2_en(lf2_en),
        .is_store(is_store), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_oor(mem_rsp_oor), .done(done),
        .result_addr(result_addr), .result_exc(result_exc)
    );

    typedef struct {
        logic [63:0] addr;
        logic [3:0]  exc;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [63:0] mem [logic [63:0]];
    int checks = 0, errors = 0, done_cnt = 0, fetch_cnt = 0;

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // memory model with fixed latency
    int          pend_cnt = -1;
    logic [63:0] pend_addr = '0;
    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pend_cnt == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
            mem_rsp_oor   <= (pend_addr >= OOR_BASE);
            pend_cnt = -1;
        end else if (pend_cnt > 0) begin
            pend_cnt--;
        end
        if (rst_n && mem_req_valid) begin
            fetch_cnt++;
            pend_addr = mem_req_addr;
            pend_cnt  = RSP_LAT - 1;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R14 unexpected done", {60'd0, result_exc}, 64'd0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                chk(result_exc == it.exc, {it.tag, " exc"}, {60'd0, result_exc}, {60'd0, it.exc});
                chk(result_addr == it.addr, {it.tag, " addr"}, result_addr, it.addr);
            end
        end
    end

    function automatic logic [63:0] mk_va(int rf, int rs, int rt, int sx, int px, int bx);
        return {11'(rf), 11'(rs), 11'(rt), 11'(sx), 8'(px), 12'(bx)};
    endfunction
    function automatic logic [63:0] mk_desc(logic [63:0] org, logic p, logic r,
                                            logic [1:0] dt, logic [1:0] tl);
        return (org & ~64'hFFF) | (64'(p) << 8) | (64'(r) << 5) | (64'(dt) << 2) | 64'(tl);
    endfunction
    function automatic logic [63:0] mk_reg(logic [63:0] org, logic [1:0] tf, logic [1:0] tl,
                                           logic [1:0] tt, logic inv, logic prot,
                                           logic comm, logic fc);
        return (org & ~64'hFFF) | (64'(fc) << 10) | (64'(prot) << 9) | (64'(tf) << 6)
             | (64'(inv) << 5) | (64'(comm) << 4) | (64'(tt) << 2) | 64'(tl);
    endfunction
    function automatic logic [63:0] mk_seg(logic [63:0] org, logic inv, logic prot,
                                           logic comm, logic fc, logic [1:0] tt);
        return (org & ~64'h7FF) | (64'(fc) << 10) | (64'(prot) << 9) | (64'(inv) << 5)
             | (64'(comm) << 4) | (64'(tt) << 2);
    endfunction
    function automatic logic [63:0] mk_pte(logic [63:0] frame, logic inv, logic prot,
                                           logic z, logic co);
        return (frame & ~64'hFFF) | (64'(z) << 11) | (64'(inv) << 10) | (64'(prot) << 9)
             | (64'(co) << 8);
    endfunction

    task automatic run(input logic [63:0] v, input logic [63:0] d, input logic e1,
                       input logic e2, input logic st, input logic [63:0] ea,
                       input logic [3:0] ee, input int ef, input string tag,
                       input logic probe_busy);
        exp_t it;
        int   f0, d0;
        it.addr = ea; it.exc = ee; it.tag = tag;
        exp_q.push_back(it);
        f0 = fetch_cnt; d0 = done_cnt;
        @(negedge clk);
        vaddr = v; space_desc = d; lf1_en = e1; lf2_en = e2; is_store = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (probe_busy) begin
            @(negedge clk);
            chk(busy == 1'b1, "R13 busy during walk", {63'd0, busy}, 64'd1);
            vaddr = 64'hDEAD_0000; space_desc = mk_desc(0, 0, 1, 0, 0); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == d0) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R14 done one cycle"}, {63'd0, done}, 64'd0);
        chk(fetch_cnt - f0 == ef, {tag, " fetch count"}, 64'(fetch_cnt - f0), 64'(ef));
        if (probe_busy) begin
            repeat (6) @(negedge clk);
            chk(done_cnt == d0 + 1, "R13 start while busy ignored",
                64'(done_cnt - d0), 64'd1);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] v, d, sd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !mem_req_valid, "reset state idle",
            {61'd0, busy, done, mem_req_valid}, 64'd0);
        rst_n = 1'b1;

        // R1 real space
        v = 64'h1234_5678_9ABC_DEF0;
        run(v, mk_desc(64'h5000, 0, 1, 0, 3), 0, 0, 1, v, 4'd0, 0, "R1 real space", 0);

        // R2 segment-only walk
        mem.delete();
        sd = mk_desc(64'h10000, 0, 0, 0, 3);
        mem[64'h10028] = mk_seg(64'h20800, 0, 0, 0, 0, 0);
        mem[64'h20818] = mk_pte(64'h73000, 0, 0, 0, 0);
        run(mk_va(0, 0, 0, 5, 3, 12'h123), sd, 0, 0, 0, 64'h73123, 4'd0, 2, "R2 segment walk", 0);

        // R11 page protection: store refused, fetch allowed
        mem[64'h20818] = mk_pte(64'h73000, 0, 1, 0, 0);
        run(mk_va(0, 0, 0, 5, 3, 12'h123), sd, 0, 0, 1, 64'd0, 4'd8, 2, "R11 store protected", 0);
        run(mk_va(0, 0, 0, 5, 3, 12'h123), sd, 0, 0, 0, 64'h73123, 4'd0, 2, "R11 fetch protected page", 0);

        // R10 page entry checks
        mem[64'h20818] = mk_pte(64'h73000, 1, 0, 0, 0);
        run(mk_va(0, 0, 0, 5, 3, 0), sd, 0, 0, 0, 64'd0, 4'd6, 2, "R10 page invalid", 0);
        mem[64'h20818] = mk_pte(64'h73000, 0, 0, 1, 0);
        run(mk_va(0, 0, 0, 5, 3, 0), sd, 0, 0, 0, 64'd0, 4'd7, 2, "R10 page bit11", 0);
        mem[64'h20818] = mk_pte(64'h73000, 0, 0, 0, 1);
        run(mk_va(0, 0, 0, 5, 3, 0), sd, 0, 0, 0, 64'd0, 4'd7, 2, "R10 page bit8 no enable", 0);
        run(mk_va(0, 0, 0, 5, 3, 12'h004), sd, 1, 0, 0, 64'h73004, 4'd0, 2, "R10 page bit8 enabled", 0);

        // R3 ASCE-type on nonzero higher index
        run(mk_va(0, 0, 1, 5, 3, 0), sd, 0, 0, 0, 64'd0, 4'd1, 0, "R3 higher index nonzero", 0);

        // R4 length check at start (region-second, length 0, index top bits 2)
        run(mk_va(0, 11'h400, 0, 0, 0, 0), mk_desc(64'h1000, 0, 0, 2, 0), 0, 0, 0,
            64'd0, 4'd3, 0, "R4 start length", 0);

        // R3 full walk from region-first (plus R13 busy probe)
        mem.delete();
        mem[64'h1010] = mk_reg(64'h2000, 0, 3, 3, 0, 0, 0, 0);
        mem[64'h2008] = mk_reg(64'h3000, 0, 3, 2, 0, 0, 0, 0);
        mem[64'h3020] = mk_reg(64'h4000, 0, 3, 1, 0, 0, 0, 0);
        mem[64'h4038] = mk_seg(64'h5000, 0, 0, 0, 0, 0);
        mem[64'h5048] = mk_pte(64'hABCD000, 0, 0, 0, 0);
        d = mk_desc(64'h1000, 0, 0, 3, 3);
        v = mk_va(2, 1, 4, 7, 9, 12'hFFF);
        run(v, d, 0, 0, 0, 64'hABCDFFF, 4'd0, 5, "R3 region-first walk", 0);
        run(v, d, 0, 0, 0, 64'hABCDFFF, 4'd0, 5, "R13 walk with busy start", 1);

        // region-third start tests
        mem.delete();
        d = mk_desc(64'h1000, 0, 0, 1, 3);
        mem[64'h1010] = mk_reg(64'h4000, 0, 3, 1, 1, 0, 0, 0);
        run(mk_va(0, 0, 2, 0, 0, 0), d, 0, 0, 0, 64'd0, 4'd4, 1, "R5 invalid region-third", 0);
        mem[64'h1010] = mk_reg(64'h4000, 0, 3, 2, 0, 0, 0, 0);
        run(mk_va(0, 0, 2, 0, 0, 0), d, 0, 0, 0, 64'd0, 4'd7, 1, "R6 tag mismatch", 0);
        mem[64'h1010] = mk_reg(64'h4000, 1, 3, 1, 0, 0, 0, 0);
        run(mk_va(0, 0, 2, 5, 0, 0), d, 0, 0, 0, 64'd0, 4'd5, 1, "R7 below window", 0);
        mem[64'h1010] = mk_reg(64'h4000, 0, 0, 1, 0, 0, 0, 0);
        run(mk_va(0, 0, 2, 11'h600, 0, 0), d, 0, 0, 0, 64'd0, 4'd5, 1, "R7 above window", 0);

        // R11 region protection counts only with first enable
        mem[64'h1010] = mk_reg(64'h4000, 0, 3, 1, 0, 1, 0, 0);
        mem[64'h4008] = mk_seg(64'h5000, 0, 0, 0, 0, 0);
        mem[64'h5010] = mk_pte(64'h9000, 0, 0, 0, 0);
        run(mk_va(0, 0, 2, 1, 2, 12'h010), d, 0, 0, 1, 64'h9010, 4'd0, 3, "R11 region prot ignored", 0);
        run(mk_va(0, 0, 2, 1, 2, 12'h010), d, 1, 0, 1, 64'd0, 4'd8, 3, "R11 region prot enabled", 0);

        // R8 region-third large frame
        mem[64'h1010] = mk_reg(64'h1_8000_0000, 0, 3, 1, 0, 0, 0, 1);
        v = mk_va(0, 0, 2, 11'h3FF, 8'hAB, 12'h321);
        run(v, d, 1, 1, 0, 64'h1_8000_0000 | (v & 64'h7FFF_FFFF), 4'd0, 1, "R8 region-third frame", 0);
        // R12 same entry without second enable walks on to an out-of-range table
        run(v, d, 1, 0, 0, 64'd0, 4'd9, 2, "R12 out-of-range table", 0);
        // R9 region-third common bit with private descriptor
        mem[64'h1010] = mk_reg(64'h4000, 0, 3, 1, 0, 0, 1, 0);
        run(mk_va(0, 0, 2, 1, 2, 0), mk_desc(64'h1000, 1, 0, 1, 3), 1, 1, 0,
            64'd0, 4'd7, 1, "R9 region-third common", 0);

        // R8 segment large frame, and bit ignored without first enable
        mem.delete();
        sd = mk_desc(64'h10000, 0, 0, 0, 3);
        mem[64'h10008] = mk_seg(64'h0650_0000, 0, 0, 0, 1, 0);
        mem[64'h0650_0000 + 64'd8 * 64'h44] = mk_pte(64'h0077_7000, 0, 0, 0, 0);
        v = mk_va(0, 0, 0, 1, 8'h44, 12'h0AB);
        run(v, sd, 1, 0, 0, 64'h0650_0000 | (v & 64'hF_FFFF), 4'd0, 1, "R8 segment frame", 0);
        run(v, sd, 0, 0, 0, 64'h0077_70AB, 4'd0, 2, "R8 segment format ignored", 0);

        // R9 segment common bit
        mem[64'h10008] = mk_seg(64'h0650_0000, 0, 0, 1, 0, 0);
        run(v, mk_desc(64'h10000, 1, 0, 0, 3), 0, 0, 0, 64'd0, 4'd7, 1, "R9 segment common private", 0);
        run(v, sd, 0, 0, 0, 64'h0077_70AB, 4'd0, 2, "R9 segment common not private", 0);

        // R12 out-of-range first table
        run(mk_va(0, 0, 0, 0, 0, 0), mk_desc(64'h9000_0000, 0, 0, 0, 3), 0, 0, 0,
            64'd0, 4'd9, 1, "R12 out-of-range first fetch", 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R14 all results seen", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule